// File: doc/BRIEF.md
# SPI Serial-Clock Half-Period Generator

This block derives the serial-clock timing of an SPI host from one fixed functional clock. Two counters in cascade set the rate. The first is a power-of-two prescaler selected by a 2-bit exponent N. The second is a modulo counter set by an 8-bit divisor n. Each half-period of the serial clock lasts (n+1)·2^N functional-clock cycles. At the end of every half-period the block emits a one-cycle tick, and the shift engine toggles SCK on that tick. The resulting bit rate is fclk / (2·(n+1)·2^N).

The divisor and exponent inputs are copied into internal holding registers on every cycle while `run` is low. These copies stay frozen while `run` is high, so the controller programs the rate while it is disabled. Raising `run` starts both counters from zero, which makes the first half-period full length. Dropping `run` clears the counters and silences the tick.

A combinational helper sits beside the counters. It reports the half-period length and the bit rate that the present inputs would give, and it also reports the fastest and slowest rates the block can reach for the functional-clock frequency parameter. The helper is meant for checking rate settings. The block has no data stream, so there is no valid/ready interface, and every pin is a plain control or status signal.

Top module: `spi_bitrate_gen`

## Requirements
- R1: While `run` is high, `tick` is high for exactly one cycle at the end of each half-period of H = (n+1)·2^N cycles, where n is `div_n` and N is `pre_exp` (prescale 1, 2, 4 or 8 for N = 0..3), both as held at the last cycle `run` was low.
- R2: The first half-period after `run` rises has full length: counting the first rising clock edge that samples `run` high as edge 0, `tick` is first high just after edge H-1.
- R3: Whenever `run` is sampled low, `tick` is low after that edge, and both counters return to zero, so after the next rise of `run` the timing again follows R2.
- R4: Changes to `div_n` or `pre_exp` while `run` is high have no effect on the tick timing until `run` has been low for at least one edge and rises again.
- R5: With n = 0 and N = 0 (fastest rate, fclk/2), `tick` is high on every cycle while `run` is high.
- R6: With n = 255 and N = 3 (slowest rate, fclk/4096), ticks are 2048 cycles apart.
- R7: `half_len` combinationally equals (div_n+1)·2^pre_exp of the present inputs, which ranges from 1 to 2048.
- R8: `rate_hz` combinationally equals ceil(FCLK_HZ / (2·half_len)) for the present inputs.
- R9: `rate_max_hz` equals ceil(FCLK_HZ/2) and `rate_min_hz` equals ceil(FCLK_HZ/4096). With the default 200 MHz these are 100000000 and 48829.
- R10: After reset `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Generator enable; settings are captured while low |
| div_n | input | 8 | Divisor n, 0..255 |
| pre_exp | input | 2 | Prescale exponent N, prescale 2^N |
| tick | output | 1 | One-cycle pulse at the end of each half-period |
| half_len | output | 12 | Half-period length in cycles for the present inputs |
| rate_hz | output | 32 | Bit rate in Hz for the present inputs, rounded up |
| rate_max_hz | output | 32 | Fastest reachable bit rate in Hz |
| rate_min_hz | output | 32 | Slowest reachable bit rate in Hz |

## Verification
`tick` leaves a single register, so it is due one clock after the edge that ends a half-period. The bench therefore counts the edges since `run` was first sampled high and compares `tick`, at the falling edge that follows each rising edge, against ((j+1) mod H == 0). For the same reason `tick` must be low at the falling edge after the first edge that samples `run` low. The helper outputs are combinational, so they are checked a short delay after the inputs change, with no clock edge in between.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned EXP_W  = 2;
  localparam int unsigned PRE_W  = (1 << EXP_W) - 1;
  localparam int unsigned HALF_W = DIV_W + PRE_W + 1;
  localparam int unsigned RATE_W = 32;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [EXP_W-1:0] exp;
  } brg_cfg_t;
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
  import spi_brg_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  localparam int unsigned CW = (1 << EW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [EW-1:0] exp_q,
  output logic          strobe
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] top;

  // Terminal count is 2^exp - 1; each mask bit is set when exp exceeds its index.
  genvar gi;
  generate
    for (gi = 0; gi < CW; gi++) begin : g_mask
      assign top[gi] = (exp_q > EW'(gi));
    end
  endgenerate

  assign strobe = run && (cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r1_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top || $changed(exp_q));
  a_r3_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import spi_brg_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          strobe,
  input  logic [DW-1:0] div_q,
  output logic          wrap
);
  logic [DW-1:0] cnt;

  assign wrap = run && strobe && (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (strobe) cnt <= cnt + 1'b1;
  end

  a_r3_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
  a_r1_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !strobe) |=> $stable(cnt));
endmodule

// File: rtl/brg_rate_info.sv
module brg_rate_info
  import spi_brg_pkg::*;
#(
  parameter int unsigned FCLK_HZ = 200_000_000
) (
  input  brg_cfg_t           cfg,
  output logic [HALF_W-1:0]  half_len,
  output logic [RATE_W-1:0]  rate_hz,
  output logic [RATE_W-1:0]  rate_max_hz,
  output logic [RATE_W-1:0]  rate_min_hz
);
  localparam longint unsigned FCLK   = longint'(FCLK_HZ);
  localparam longint unsigned MAX_HALF = longint'(1 << DIV_W) << PRE_W;
  localparam longint unsigned FAST   = (FCLK + 1) / 2;
  localparam longint unsigned SLOW   = (FCLK + 2*MAX_HALF - 1) / (2*MAX_HALF);

  logic [RATE_W:0] num;
  logic [RATE_W:0] den;

  always_comb begin
    half_len = (HALF_W'(cfg.div) + HALF_W'(1)) << cfg.exp;
    den      = (RATE_W+1)'({half_len, 1'b0});
    num      = (RATE_W+1)'(FCLK) + den - (RATE_W+1)'(1);
    rate_hz  = RATE_W'(num / den);
  end

  assign rate_max_hz = RATE_W'(FAST);
  assign rate_min_hz = RATE_W'(SLOW);

  always_comb begin
    a_r7_half_nonzero: assert (half_len != '0);
  end
endmodule

// File: rtl/spi_bitrate_gen.sv
module spi_bitrate_gen
  import spi_brg_pkg::*;
#(
  parameter int unsigned FCLK_HZ = 200_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [7:0]        div_n,
  input  logic [1:0]        pre_exp,
  output logic              tick,
  output logic [11:0]       half_len,
  output logic [31:0]       rate_hz,
  output logic [31:0]       rate_max_hz,
  output logic [31:0]       rate_min_hz
);
  brg_cfg_t cfg_in;
  brg_cfg_t cfg_q;
  logic     pre_strobe;
  logic     div_wrap;

  assign cfg_in.div = div_n;
  assign cfg_in.exp = pre_exp;

  // Holding registers follow the inputs only while disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (!run) cfg_q <= cfg_in;
  end

  brg_prescale #(.EW(EXP_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .exp_q  (cfg_q.exp),
    .strobe (pre_strobe)
  );

  brg_divider #(.DW(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .strobe (pre_strobe),
    .div_q  (cfg_q.div),
    .wrap   (div_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= div_wrap;
  end

  brg_rate_info #(.FCLK_HZ(FCLK_HZ)) u_info (
    .cfg         (cfg_in),
    .half_len    (half_len),
    .rate_hz     (rate_hz),
    .rate_max_hz (rate_max_hz),
    .rate_min_hz (rate_min_hz)
  );

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cfg_q.div != '0 || cfg_q.exp != '0)) |=> !tick);
  a_r5_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cfg_q.div == '0 && cfg_q.exp == '0) |-> tick);
endmodule

// File: tb/tb_spi_bitrate_gen.sv
`timescale 1ns/1ps
module tb_spi_bitrate_gen;
  localparam longint unsigned FCLK = 200_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  div_n = '0;
  logic [1:0]  pre_exp = '0;
  logic        tick;
  logic [11:0] half_len;
  logic [31:0] rate_hz, rate_max_hz, rate_min_hz;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_bitrate_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_n(div_n), .pre_exp(pre_exp),
    .tick(tick), .half_len(half_len), .rate_hz(rate_hz),
    .rate_max_hz(rate_max_hz), .rate_min_hz(rate_min_hz)
  );

  function automatic longint unsigned f_half(int n, int e);
    return longint'(n + 1) * (longint'(1) << e);
  endfunction

  function automatic longint unsigned f_rate(longint unsigned h);
    return (FCLK + 2*h - 1) / (2*h);
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_info(int n, int e);
    @(negedge clk);
    div_n = 8'(n); pre_exp = 2'(e);
    #1;
    chk("R7", half_len, f_half(n, e));
    chk("R8", rate_hz, f_rate(f_half(n, e)));
  endtask

  // Runs the generator with (n,e) for ncyc edges; optionally disturbs inputs mid-run.
  task automatic run_cfg(int n, int e, int ncyc, bit disturb, string req);
    longint unsigned h = f_half(n, e);
    int bad = 0;
    @(negedge clk);
    run = 1'b0; div_n = 8'(n); pre_exp = 2'(e);
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    for (int j = 0; j < ncyc; j++) begin
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (tick != (((longint'(j) + 1) % h) == 0)) begin
        fails++; bad++;
        if (bad < 4)
          $display("FAIL %s: tick actual %0b expected %0b at edge %0d (H=%0d)",
                   req, tick, !tick, j, h);
      end
      if (disturb && j == 2) begin
        div_n = 8'($urandom_range(255)); pre_exp = 2'($urandom_range(3)); // R4
      end
    end
    run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R3", tick, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3", tick, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    #1 chk("R10", tick, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", tick, 0);

    chk("R9", rate_max_hz, 100_000_000);
    chk("R9", rate_min_hz, 48829);

    chk_info(0, 0);
    chk_info(255, 3);
    chk_info(7, 2);
    chk_info(99, 1);
    for (int k = 0; k < 12; k++) chk_info($urandom_range(255), $urandom_range(3));

    run_cfg(0, 0, 16, 0, "R5");
    run_cfg(1, 0, 12, 0, "R2");
    run_cfg(0, 1, 12, 0, "R1");
    run_cfg(3, 2, 64, 0, "R1");
    run_cfg(255, 3, 4200, 0, "R6");
    run_cfg(4, 1, 60, 1, "R4");
    run_cfg(0, 0, 10, 1, "R4");
    for (int k = 0; k < 20; k++)
      run_cfg($urandom_range(31), $urandom_range(3), 3 * 32 * 8 + 5, ($urandom_range(1) == 1), "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule